// File: doc/BRIEF.md
# Cache Miss Type Classifier

This block watches a stream of memory block addresses and puts every access into one of four classes: a hit in a direct-mapped cache, a cold miss, a conflict miss or a capacity miss. It holds no data. It keeps three kinds of bookkeeping state. The first is a tag array that behaves like the direct-mapped cache being studied. The second is a fully associative shadow tag store with the same number of lines, managed by true least-recently-used replacement. The third is a bit vector that records which block addresses have been referenced since the last clear.

The class of each access is fixed by priority. A direct-mapped hit is a hit. Otherwise, a block never seen before is a cold miss. A seen block that the shadow store still holds is a conflict miss, because a cache of the same size without placement limits would have kept it. Any other miss is a capacity miss. The result appears one cycle after the access strobe. Four saturating counters keep the running total of each class. A small state machine has two states. In `S_IDLE` no result is shown. In `S_RESULT` the result of the previous cycle's access is shown. The transition `fire` (a strobe without clear) leads into `S_RESULT` from either state. The transition `quiet` (no strobe, or a clear) leads into `S_IDLE` from either state.

Top module: `miss_classifier`

## Requirements
- R1: After reset, or one cycle after `clr` is high, `res_valid` is 0, all four counters are 0, and every block counts as never seen and absent from both tag stores.
- R2: A strobe with `clr` low gives `res_valid`=1 on the next cycle with exactly one bit of `res_code` set (bit0 hit, bit1 cold, bit2 conflict, bit3 capacity). In any cycle with `res_valid`=0, `res_code` is 0.
- R3: The direct-mapped slot is the low log2(DM_LINES) bits of the block address, and the rest of the address is the tag. A hit needs the slot valid and its tag equal. With 8 lines, blocks 1 and 9 share slot 1 and evict each other.
- R4: The first reference to a block since reset or clear is a cold miss unless it hits.
- R5: A direct-mapped miss on a seen block that is still held in the shadow store is a conflict miss. The pattern 0, 8, 0, 8 gives cold, cold, conflict, conflict.
- R6: A direct-mapped miss on a seen block that the shadow store no longer holds is a capacity miss. A direct-mapped hit is reported as a hit even when the shadow store would miss.
- R7: The shadow store is true LRU. A hit makes the entry most recent, and a miss replaces the least recent entry.
- R8: Each counter adds one for each result of its class and holds at 2^CNT_W-1.
- R9: A strobe in a cycle with `clr` high is dropped. It produces no result, no count and no mark as seen.
- R10: Without a strobe, no result appears and no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters, valid bits and seen bits |
| acc_valid | input | 1 | Access strobe |
| acc_block | input | log2(TRACK_BLOCKS) | Block address of the access |
| res_valid | output | 1 | Result of the previous cycle's access is present |
| res_code | output | 4 | One-hot class: bit0 hit, bit1 cold, bit2 conflict, bit3 capacity |
| cnt_hit | output | CNT_W | Saturating hit total |
| cnt_cold | output | CNT_W | Saturating cold-miss total |
| cnt_conflict | output | CNT_W | Saturating conflict-miss total |
| cnt_capacity | output | CNT_W | Saturating capacity-miss total |

## Verification
The bench keeps 8 direct-mapped lines, 8 shadow lines and 64 tracked blocks, so nine distinct blocks are enough to overflow the shadow store and show a capacity miss. A sequence that refreshes block 0 by a hit just before the overflow separates true LRU from first-in order. The counter width is reduced to 6 bits, which lets a run of 70 hits reach the saturation limit in a few dozen cycles instead of 65535.

// File: rtl/miss_classifier_pkg.sv
package miss_classifier_pkg;

    localparam int NUM_CLS = 4;

    typedef enum logic [1:0] {
        CLS_HIT      = 2'd0,
        CLS_COLD     = 2'd1,
        CLS_CONFLICT = 2'd2,
        CLS_CAPACITY = 2'd3
    } cls_e;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_RESULT = 1'b1
    } st_e;

endpackage

// File: rtl/dm_tag_array.sv
module dm_tag_array #(
    parameter int LINES  = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [ADDR_W-1:0] blk,
    output logic              hit
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [LINES-1:0] line_vld;
    logic [TAG_W-1:0] line_tag [LINES];
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;

    assign idx = blk[IDX_W-1:0];
    assign tag = blk[ADDR_W-1:IDX_W];

    always_comb begin
        hit = line_vld[idx] && (line_tag[idx] == tag);
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                line_vld[g] <= 1'b0;
                line_tag[g] <= '0;
            end else if (clr) begin
                line_vld[g] <= 1'b0;
                line_tag[g] <= '0;
            end else if (upd && (idx == IDX_W'(g))) begin
                line_vld[g] <= 1'b1;
                line_tag[g] <= tag;
            end
        end
    end

    // R3: a line that has been filled stays valid until a clear
    p_vld_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && line_vld[0]) |=> line_vld[0]);

endmodule

// File: rtl/fa_lru_shadow.sv
module fa_lru_shadow #(
    parameter int LINES  = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [ADDR_W-1:0] blk,
    output logic              hit
);
    localparam int AGE_W  = $clog2(LINES);
    localparam int OLDEST = LINES - 1;

    logic [LINES-1:0]  ent_vld;
    logic [ADDR_W-1:0] ent_blk [LINES];
    logic [AGE_W-1:0]  ent_age [LINES];
    logic [LINES-1:0]  match_vec;
    logic [LINES-1:0]  oldest_vec;
    logic [LINES-1:0]  touch_vec;
    logic [AGE_W-1:0]  touch_age;

    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign match_vec[g]  = ent_vld[g] && (ent_blk[g] == blk);
        assign oldest_vec[g] = (ent_age[g] == AGE_W'(OLDEST));
    end

    always_comb begin
        hit       = |match_vec;
        touch_vec = hit ? match_vec : oldest_vec;
        touch_age = '0;
        for (int i = 0; i < LINES; i++) begin
            if (touch_vec[i]) touch_age = touch_age | ent_age[i];
        end
    end

    // Ages form a permutation; the touched entry becomes age 0 and every
    // younger entry ages by one, which keeps the permutation intact.
    for (genvar g = 0; g < LINES; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_vld[g] <= 1'b0;
                ent_blk[g] <= '0;
                ent_age[g] <= AGE_W'(g);
            end else if (clr) begin
                ent_vld[g] <= 1'b0;
                ent_blk[g] <= '0;
                ent_age[g] <= AGE_W'(g);
            end else if (upd) begin
                if (touch_vec[g]) begin
                    ent_vld[g] <= 1'b1;
                    ent_blk[g] <= blk;
                    ent_age[g] <= '0;
                end else if (ent_age[g] < touch_age) begin
                    ent_age[g] <= ent_age[g] + 1'b1;
                end
            end
        end
    end

    // R7: exactly one least-recent entry exists at all times
    p_one_oldest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);

    // R7: a block is held in at most one shadow entry
    p_unique_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

endmodule

// File: rtl/seen_table.sv
module seen_table #(
    parameter int BLOCKS = 64,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [ADDR_W-1:0] blk,
    output logic              seen
);
    logic [BLOCKS-1:0] seen_q;

    assign seen = seen_q[blk];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (clr) begin
            seen_q <= '0;
        end else if (upd) begin
            seen_q[blk] <= 1'b1;
        end
    end

    // R4: an access marks its block as seen
    p_mark_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr) |=> seen_q[$past(blk)]);

    // R1: a clear empties the table
    p_clear_seen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (seen_q == '0));

endmodule

// File: rtl/class_counter.sv
module class_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (cnt == CNT_MAX)) |=> (cnt == CNT_MAX));

    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)));

    p_no_inc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt));

endmodule

// File: rtl/miss_classifier.sv
module miss_classifier #(
    parameter int DM_LINES     = 8,
    parameter int FA_LINES     = 8,
    parameter int TRACK_BLOCKS = 64,
    parameter int CNT_W        = 16,
    localparam int ADDR_W      = $clog2(TRACK_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_block,
    output logic              res_valid,
    output logic [3:0]        res_code,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_cold,
    output logic [CNT_W-1:0]  cnt_conflict,
    output logic [CNT_W-1:0]  cnt_capacity
);
    import miss_classifier_pkg::*;

    st_e              state_q, state_d;
    cls_e             cls_d, cls_q;
    logic             fire;
    logic             dm_hit, fa_hit, was_seen;
    logic [CNT_W-1:0] cnt_arr [NUM_CLS];

    assign fire = acc_valid && !clr;

    dm_tag_array #(.LINES(DM_LINES), .ADDR_W(ADDR_W)) u_dm (
        .clk(clk), .rst_n(rst_n), .clr(clr), .upd(fire),
        .blk(acc_block), .hit(dm_hit)
    );

    fa_lru_shadow #(.LINES(FA_LINES), .ADDR_W(ADDR_W)) u_fa (
        .clk(clk), .rst_n(rst_n), .clr(clr), .upd(fire),
        .blk(acc_block), .hit(fa_hit)
    );

    seen_table #(.BLOCKS(TRACK_BLOCKS), .ADDR_W(ADDR_W)) u_seen (
        .clk(clk), .rst_n(rst_n), .clr(clr), .upd(fire),
        .blk(acc_block), .seen(was_seen)
    );

    always_comb begin
        if (dm_hit)        cls_d = CLS_HIT;
        else if (!was_seen) cls_d = CLS_COLD;
        else if (fa_hit)   cls_d = CLS_CONFLICT;
        else               cls_d = CLS_CAPACITY;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   state_d = fire ? S_RESULT : S_IDLE;
            S_RESULT: state_d = fire ? S_RESULT : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cls_q   <= CLS_HIT;
        end else begin
            state_q <= state_d;
            if (fire) cls_q <= cls_d;
        end
    end

    always_comb begin
        res_valid = (state_q == S_RESULT);
        res_code  = res_valid ? (4'b0001 << cls_q) : 4'b0000;
    end

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_cnt
        class_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .inc(fire && (cls_d == cls_e'(g))),
            .cnt(cnt_arr[g])
        );
    end

    assign cnt_hit      = cnt_arr[0];
    assign cnt_cold     = cnt_arr[1];
    assign cnt_conflict = cnt_arr[2];
    assign cnt_capacity = cnt_arr[3];

    p_onehot_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones(res_code) == 1));

    p_quiet_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_code == 4'b0000));

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(acc_valid && !clr));

    p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !res_valid);

    p_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);

endmodule

// File: tb/miss_classifier_bench.sv
module miss_classifier_bench;

    localparam int CW      = 6;
    localparam int AW      = 6;
    localparam int MAXC    = (1 << CW) - 1;
    localparam logic [3:0] C_HIT = 4'b0001;
    localparam logic [3:0] C_CLD = 4'b0010;
    localparam logic [3:0] C_CNF = 4'b0100;
    localparam logic [3:0] C_CAP = 4'b1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_block = '0;
    logic          res_valid;
    logic [3:0]    res_code;
    logic [CW-1:0] cnt_hit, cnt_cold, cnt_conflict, cnt_capacity;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int exp_cnt [4];
    logic [3:0] exp_q [$];
    string      req_q [$];

    always #10 clk = ~clk;

    miss_classifier #(.DM_LINES(8), .FA_LINES(8), .TRACK_BLOCKS(64), .CNT_W(CW)) u_miss_classifier (
        .clk(clk), .rst_n(rst_n), .clr(clr), .acc_valid(acc_valid),
        .acc_block(acc_block), .res_valid(res_valid), .res_code(res_code),
        .cnt_hit(cnt_hit), .cnt_cold(cnt_cold),
        .cnt_conflict(cnt_conflict), .cnt_capacity(cnt_capacity)
    );

    // Monitor: pops expected classes as results appear
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R2 unexpected result code=%b expected none", res_code);
            end else begin
                logic [3:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                if (res_code !== e) begin
                    failures++;
                    $display("FAIL %s code actual=%b expected=%b", r, res_code, e);
                end
            end
        end
    end

    // Driver: strobe one access, starting at a falling edge
    task automatic access(input int blk, input logic [3:0] code, input string req);
        acc_valid = 1'b1;
        acc_block = AW'(blk);
        exp_q.push_back(code);
        req_q.push_back(req);
        for (int k = 0; k < 4; k++) begin
            if (code[k] && exp_cnt[k] != MAXC) exp_cnt[k]++;
        end
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        acc_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic check_counts(input string req);
        logic [CW-1:0] act [4];
        act[0] = cnt_hit; act[1] = cnt_cold; act[2] = cnt_conflict; act[3] = cnt_capacity;
        for (int k = 0; k < 4; k++) begin
            checks++;
            if (act[k] !== CW'(exp_cnt[k])) begin
                failures++;
                $display("FAIL %s counter %0d actual=%0d expected=%0d", req, k, act[k], exp_cnt[k]);
            end
        end
    endtask

    task automatic check_quiet(input string req);
        checks++;
        if (res_valid !== 1'b0 || res_code !== 4'b0000) begin
            failures++;
            $display("FAIL %s quiet outputs actual=%b/%b expected=0/0000", req, res_valid, res_code);
        end
    endtask

    // Clear, optionally with a strobe in the same cycle
    task automatic do_clear(input bit with_strobe, input int blk);
        clr = 1'b1;
        acc_valid = with_strobe;
        acc_block = AW'(blk);
        @(negedge clk);
        clr = 1'b0;
        acc_valid = 1'b0;
        for (int k = 0; k < 4; k++) exp_cnt[k] = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) exp_cnt[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_quiet("R1");
        check_counts("R1");

        // R4/R5: slot sharing pattern 0,8,0,8
        access(0, C_CLD, "R4");
        access(8, C_CLD, "R4");
        access(0, C_CNF, "R5");
        access(8, C_CNF, "R5");
        // R3: resident block hits, new tag in same slot is cold
        access(8, C_HIT, "R3");
        access(16, C_CLD, "R3");
        access(8, C_CNF, "R5");
        // R3: blocks 1 and 9 share slot 1
        access(1, C_CLD, "R3");
        access(9, C_CLD, "R3");
        access(9, C_HIT, "R3");
        access(1, C_CNF, "R3");
        check_counts("R8");

        // R10: idle cycles give no result and no count change
        idle(4);
        check_quiet("R10");
        check_counts("R10");

        // R1: clear forgets seen blocks
        do_clear(1'b0, 0);
        check_quiet("R1");
        check_counts("R1");
        access(0, C_CLD, "R1");
        access(0, C_HIT, "R2");

        // R9: strobe during clear is dropped
        do_clear(1'b1, 5);
        check_quiet("R9");
        check_counts("R9");
        access(5, C_CLD, "R9");
        access(0, C_CLD, "R9");
        check_counts("R9");

        // R6: nine distinct blocks overflow the shadow store
        do_clear(1'b0, 0);
        for (int b = 0; b < 9; b++) access(b, C_CLD, "R4");
        access(0, C_CAP, "R6");
        access(1, C_HIT, "R6");
        check_counts("R6");

        // R7: a hit refreshes recency, so block 1 is evicted before block 0
        do_clear(1'b0, 0);
        for (int b = 0; b < 8; b++) access(b, C_CLD, "R4");
        access(0, C_HIT, "R7");
        access(8, C_CLD, "R7");
        access(0, C_CNF, "R7");
        access(9, C_CLD, "R7");
        access(1, C_CAP, "R7");
        check_counts("R7");

        // R8: saturation of the hit counter
        do_clear(1'b0, 0);
        access(3, C_CLD, "R8");
        for (int n = 0; n < 70; n++) access(3, C_HIT, "R8");
        check_counts("R8");

        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R2 missing results actual=0 expected=%0d", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule